// File: doc/BRIEF.md
# Emergency-Preempt Traffic Light Controller

This block is a synchronous Moore state machine that drives the three lamps (red, yellow, green) facing the main road at a two-road junction. The main road normally holds green. After a run of green cycles, the controller checks whether a car is waiting on the side road. If no car is waiting, green starts a new run. If a car is waiting, the lamps step through yellow and then a fixed minimum red.

An active-low emergency input preempts green at any point in the green run. The controller then shows a single shortened yellow and goes to red. It keeps red for as long as the emergency stays asserted once the minimum red has elapsed.

Every delay is a chain of successive states; no separate counter exists. The lamps are decoded from the registered state alone, and the state register is exported so that the present state is always visible.

Top module: `tl_preempt_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0 (first green state), with only `lamp_grn` lit.
- R2: With the emergency inactive, green stays lit for exactly six consecutive cycles, in states 0 through 5.
- R3: In state 5, with no emergency and `car_wait` low, the next state is 0 and green continues. With `car_wait` high, the next state is 6 (yellow).
- R4: Normal yellow lasts two cycles (states 6 and 7) and is followed by red state 9. `emg_n` has no effect while in normal yellow.
- R5: Red lasts at least four cycles (states 9 to 12), and `emg_n` has no effect in states 9 to 11. In state 12 with `emg_n` high, the next state is 0 (green).
- R6: `emg_n` low, sampled at a clock edge in any green state 0 to 5, moves the machine to state 8. State 8 shows yellow for exactly one cycle and then goes to red state 9. This takes priority over `car_wait`.
- R7: In state 12 with `emg_n` low, red is held and the state stays 12. On the first edge that samples `emg_n` high, the next state is 0.
- R8: Exactly one lamp is lit in every cycle. The lamps depend only on the registered state, so an input change between edges does not change them.
- R9: `state_bits` carries the state encoding: 0 to 5 are green, 6 and 7 are normal yellow, 8 is emergency yellow, and 9 to 12 are red. Codes 13 to 15 light red and return to state 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_wait | input | 1 | Side-road car waiting, active high |
| emg_n | input | 1 | Emergency vehicle approaching, active low |
| lamp_red | output | 1 | Main-road red lamp, active high |
| lamp_yel | output | 1 | Main-road yellow lamp, active high |
| lamp_grn | output | 1 | Main-road green lamp, active high |
| state_bits | output | 4 | Present state register |

## Verification
A wrong state transition shows up at `state_bits` on the very next clock, because every state has its own code. It shows up at the lamps on the clock where the phase boundary moves. Examples are a green run of the wrong length, a yellow that is too long after preemption, or red released while the emergency is still active. The directed scenarios walk every state and compare the state code and the lamp triple against expected values on every cycle. A single misplaced transition is therefore caught within one cycle of the point where it occurs. The unreachable codes can only be exercised by a checker property, since no input sequence leads to them.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamps_t;

  localparam lamps_t LAMP_RED = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
  localparam lamps_t LAMP_YEL = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
  localparam lamps_t LAMP_GRN = '{red: 1'b0, yel: 1'b0, grn: 1'b1};

endpackage

// File: rtl/tl_state_reg.sv
module tl_state_reg #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/tl_next_state.sv
module tl_next_state #(
  parameter int GREEN_CYC = 6,
  parameter int YEL_CYC   = 2,
  parameter int RED_MIN   = 4,
  parameter int W         = 4
) (
  input  logic [W-1:0] cur,
  input  logic         emg_act,
  input  logic         car_wait,
  output logic [W-1:0] nxt
);

  // Encoding: green chain, normal yellow chain, one emergency yellow, red chain.
  localparam logic [W-1:0] S_G0    = '0;
  localparam logic [W-1:0] S_GLAST = W'(GREEN_CYC - 1);
  localparam logic [W-1:0] S_YN0   = W'(GREEN_CYC);
  localparam logic [W-1:0] S_YLAST = W'(GREEN_CYC + YEL_CYC - 1);
  localparam logic [W-1:0] S_YE    = W'(GREEN_CYC + YEL_CYC);
  localparam logic [W-1:0] S_R0    = W'(GREEN_CYC + YEL_CYC + 1);
  localparam logic [W-1:0] S_RLAST = W'(GREEN_CYC + YEL_CYC + RED_MIN);

  always_comb begin
    nxt = S_G0;
    if (cur <= S_GLAST) begin
      if (emg_act)             nxt = S_YE;
      else if (cur == S_GLAST) nxt = car_wait ? S_YN0 : S_G0;
      else                     nxt = cur + 1'b1;
    end else if (cur <= S_YLAST) begin
      nxt = (cur == S_YLAST) ? S_R0 : cur + 1'b1;
    end else if (cur == S_YE) begin
      nxt = S_R0;
    end else if (cur < S_RLAST) begin
      nxt = cur + 1'b1;
    end else if (cur == S_RLAST) begin
      nxt = emg_act ? S_RLAST : S_G0;
    end else begin
      nxt = S_G0;
    end
  end

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
#(
  parameter int GREEN_CYC = 6,
  parameter int YEL_CYC   = 2,
  parameter int RED_MIN   = 4,
  parameter int W         = 4
) (
  input  logic [W-1:0] cur,
  output lamps_t       lamps
);

  localparam int N_ST = GREEN_CYC + YEL_CYC + 1 + RED_MIN;

  lamps_t table_q [N_ST];

  for (genvar s = 0; s < N_ST; s++) begin : g_tab
    if (s < GREEN_CYC) begin : g_grn
      assign table_q[s] = LAMP_GRN;
    end else if (s <= GREEN_CYC + YEL_CYC) begin : g_yel
      assign table_q[s] = LAMP_YEL;
    end else begin : g_red
      assign table_q[s] = LAMP_RED;
    end
  end

  always_comb begin
    lamps = LAMP_RED;
    for (int i = 0; i < N_ST; i++) begin
      if (cur == W'(i)) lamps = table_q[i];
    end
  end

endmodule

// File: rtl/tl_preempt_ctrl.sv
module tl_preempt_ctrl
  import tl_pkg::*;
#(
  parameter int GREEN_CYC = 6,
  parameter int YEL_CYC   = 2,
  parameter int RED_MIN   = 4,
  localparam int N_ST     = GREEN_CYC + YEL_CYC + 1 + RED_MIN,
  localparam int W        = $clog2(N_ST)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         car_wait,
  input  logic         emg_n,
  output logic         lamp_red,
  output logic         lamp_yel,
  output logic         lamp_grn,
  output logic [W-1:0] state_bits
);

  logic [W-1:0] cur_q;
  logic [W-1:0] nxt_d;
  lamps_t       lamps;
  logic         emg_act;

  assign emg_act = ~emg_n;

  tl_next_state #(
    .GREEN_CYC(GREEN_CYC), .YEL_CYC(YEL_CYC), .RED_MIN(RED_MIN), .W(W)
  ) u_next (
    .cur(cur_q), .emg_act(emg_act), .car_wait(car_wait), .nxt(nxt_d)
  );

  tl_state_reg #(.W(W), .RST_VAL('0)) u_reg (
    .clk(clk), .rst(rst), .d(nxt_d), .q(cur_q)
  );

  tl_lamp_decode #(
    .GREEN_CYC(GREEN_CYC), .YEL_CYC(YEL_CYC), .RED_MIN(RED_MIN), .W(W)
  ) u_dec (
    .cur(cur_q), .lamps(lamps)
  );

  assign lamp_red   = lamps.red;
  assign lamp_yel   = lamps.yel;
  assign lamp_grn   = lamps.grn;
  assign state_bits = cur_q;

endmodule

// File: rtl/tl_preempt_chk.sv
module tl_preempt_chk #(
  parameter int GREEN_CYC = 6,
  parameter int YEL_CYC   = 2,
  parameter int RED_MIN   = 4,
  parameter int W         = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         car_wait,
  input logic         emg_n,
  input logic         lamp_red,
  input logic         lamp_yel,
  input logic         lamp_grn,
  input logic [W-1:0] state_bits
);

  localparam logic [W-1:0] S_GLAST = W'(GREEN_CYC - 1);
  localparam logic [W-1:0] S_YN0   = W'(GREEN_CYC);
  localparam logic [W-1:0] S_YE    = W'(GREEN_CYC + YEL_CYC);
  localparam logic [W-1:0] S_R0    = W'(GREEN_CYC + YEL_CYC + 1);
  localparam logic [W-1:0] S_RLAST = W'(GREEN_CYC + YEL_CYC + RED_MIN);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (state_bits == '0) && lamp_grn);

  p_no_car_r3: assert property (@(posedge clk) disable iff (rst)
    (state_bits == S_GLAST) && emg_n && !car_wait |=> (state_bits == '0) && lamp_grn);

  p_car_r3: assert property (@(posedge clk) disable iff (rst)
    (state_bits == S_GLAST) && emg_n && car_wait |=> (state_bits == S_YN0) && lamp_yel);

  p_red_min_r5: assert property (@(posedge clk) disable iff (rst)
    lamp_red && (state_bits >= S_R0) && (state_bits < S_RLAST) |=> lamp_red);

  p_preempt_r6: assert property (@(posedge clk) disable iff (rst)
    lamp_grn && !emg_n |=> lamp_yel ##1 lamp_red);

  p_short_yel_r6: assert property (@(posedge clk) disable iff (rst)
    (state_bits == S_YE) |=> (state_bits == S_R0));

  p_red_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state_bits == S_RLAST) && !emg_n |=> (state_bits == S_RLAST) && lamp_red);

  p_red_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (state_bits == S_RLAST) && emg_n |=> (state_bits == '0) && lamp_grn);

  p_one_lamp_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({lamp_red, lamp_yel, lamp_grn}) == 1);

  p_illegal_r9: assert property (@(posedge clk) disable iff (rst)
    (state_bits > S_RLAST) |-> lamp_red ##1 (state_bits == '0));

endmodule

bind tl_preempt_ctrl tl_preempt_chk #(
  .GREEN_CYC(GREEN_CYC), .YEL_CYC(YEL_CYC), .RED_MIN(RED_MIN), .W(W)
) u_chk (
  .clk(clk), .rst(rst), .car_wait(car_wait), .emg_n(emg_n),
  .lamp_red(lamp_red), .lamp_yel(lamp_yel), .lamp_grn(lamp_grn),
  .state_bits(state_bits)
);

// File: tb/sim_tl_preempt_ctrl.sv
`timescale 1ns/1ps
module sim_tl_preempt_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car_wait = 1'b0;
  logic       emg_n = 1'b1;
  logic       lamp_red, lamp_yel, lamp_grn;
  logic [3:0] state_bits;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tl_preempt_ctrl u0 (
    .clk(clk), .rst(rst), .car_wait(car_wait), .emg_n(emg_n),
    .lamp_red(lamp_red), .lamp_yel(lamp_yel), .lamp_grn(lamp_grn),
    .state_bits(state_bits)
  );

  // Expected lamps {red,yel,grn} from the R9 encoding.
  function automatic logic [2:0] exp_lamps(input int s);
    if (s <= 5)       return 3'b001;
    else if (s <= 8)  return 3'b010;
    else              return 3'b100;
  endfunction

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string tag, input int exp_s);
    logic [2:0] got;
    got = {lamp_red, lamp_yel, lamp_grn};
    checks++;
    if (state_bits !== 4'(exp_s) || got !== exp_lamps(exp_s)) begin
      failures++;
      $display("FAIL %s: state=%0d lamps=%b expected state=%0d lamps=%b",
               tag, state_bits, got, exp_s, exp_lamps(exp_s));
    end
  endtask

  task automatic step(input string tag, input int exp_s);
    tick();
    check(tag, exp_s);
  endtask

  task automatic do_reset();
    rst = 1'b1; emg_n = 1'b1; car_wait = 1'b0;
    tick(); tick();
    rst = 1'b0;
    check("R1", 0);
  endtask

  task automatic t_normal_cycle();
    do_reset();
    car_wait = 1'b1;
    for (int i = 1; i <= 5; i++) step("R2", i);
    step("R3", 6);
    emg_n = 1'b0;              // ignored in normal yellow
    step("R4", 7);
    emg_n = 1'b1;
    step("R4", 9);
    step("R5", 10);
    step("R5", 11);
    step("R5", 12);
    step("R5", 0);
  endtask

  task automatic t_no_car();
    do_reset();
    for (int i = 1; i <= 5; i++) step("R2", i);
    step("R3", 0);
    for (int i = 1; i <= 5; i++) step("R2", i);
    car_wait = 1'b1;
    step("R3", 6);
    car_wait = 1'b0;
  endtask

  task automatic t_preempt(input int k);
    do_reset();
    car_wait = (k == 5);       // emergency must win over car waiting
    for (int i = 1; i <= k; i++) step("R2", i);
    emg_n = 1'b0;
    step("R6", 8);
    emg_n = 1'b1;
    step("R6", 9);
    step("R5", 10);
    step("R5", 11);
    step("R5", 12);
    car_wait = 1'b0;
    step("R5", 0);
  endtask

  task automatic t_red_hold();
    do_reset();
    emg_n = 1'b0;
    step("R6", 8);
    step("R5", 9);             // emergency still low: no effect in red chain
    step("R5", 10);
    step("R5", 11);
    step("R5", 12);
    for (int i = 0; i < 5; i++) step("R7", 12);
    emg_n = 1'b1;
    #3;
    check("R8", 12);           // lamps unchanged until the next edge
    step("R7", 0);
    emg_n = 1'b0;
    #3;
    check("R8", 0);
    step("R6", 8);
    emg_n = 1'b1;
    step("R6", 9);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_normal_cycle();
    t_no_car();
    t_preempt(0);
    t_preempt(2);
    t_preempt(5);
    t_red_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule